// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block buffers audio samples between a CPU or DMA bus and a serial audio port. It holds one queue for outgoing samples and one for incoming samples. A control/status word configures it and reports its state, a threshold word sets the fill levels at which DMA service is requested, and a data port loads the transmit queue and drains the receive queue. The serializer side moves words through strobes: it pops outgoing words and pushes incoming ones. The serializer is not part of this block.

Four level-based outputs drive an external DMA engine. Each direction has a normal service request and a more urgent panic request. Underruns and overruns set sticky error flags, and software clears them by writing one to them. Three operations take effect only after a set number of serial-clock cycles, counted from a single-cycle `sclk_tick` strobe: clearing a queue, the sync handshake bit, and leaving standby. Software can poll the sync bit to confirm that serial time has passed.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset, the thresholds read 0 and the control word reads 0x002E0000. That is four bits set: bit 17 (transmit at or below its request level), bit 18 (receive at or above its request level), bit 19 (transmit not full) and bit 21 (transmit empty). All four DMA outputs are low.
- R2: A write to the data port (address 1) appends a word to the transmit queue and is dropped when the queue is full. Serial pops deliver the words in the order they were written. Bit 19 reads 0 when the transmit queue is full.
- R3: Serial pushes fill the receive queue. A data-port read (address 1) returns the oldest word and removes it. Bit 20 shows that the receive queue is not empty, and bit 22 shows that it is full.
- R4: The threshold word (address 2) holds the receive request level in bits 7:0, the transmit request level in bits 15:8, the receive panic level in bits 23:16 and the transmit panic level in bits 31:24. `tx_dreq` is high when the transmit level is at or below its request level, and `tx_panic` is high when the level is at or below its panic level.
- R5: `rx_dreq` is high when the receive level is at or above its request level, and `rx_panic` is high when the level is at or above its panic level.
- R6: All four DMA outputs stay low unless enable (bit 0) and DMA-enable (bit 9) are both set.
- R7: A serial pop while the transmit queue is empty and the transmit path is active sets the error flag in bit 15. Writing 1 to bit 15 clears it.
- R8: A serial push while the receive queue is full drops the word and sets the error flag in bit 16. Writing 1 to bit 16 clears it.
- R9: Writing 1 to bit 3 (transmit) or bit 4 (receive) empties that queue on the second serial-clock tick after the write, and not before.
- R10: The sync bit (bit 24) reads back a newly written value only from the second serial-clock tick after the write.
- R11: Serial strobes take effect only when enable is set, the direction's on bit is set (receive bit 1, transmit bit 2), and the wake bit (bit 25) was set at least four serial-clock ticks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_tick | input | 1 | One-cycle strobe per serial-clock cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data-port read pops the receive queue) |
| reg_addr | input | 2 | 0 control/status, 1 data port, 2 thresholds |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ser_tx_pop | input | 1 | Serializer takes the head transmit word |
| ser_tx_data | output | 32 | Head of the transmit queue |
| ser_rx_push | input | 1 | Serializer delivers a received word |
| ser_rx_data | input | 32 | Received word |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit urgent request |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive urgent request |

## Verification
The bench builds the block with a queue depth of 8 instead of 64. This makes the full, overflow and dropped-write cases reachable within a few dozen cycles, while the 8-bit threshold fields still span every fill level. The clear and sync delays stay at two ticks and the wake delay at four ticks. The bench issues each tick by hand, so it can sample one tick before and one tick at each boundary.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int B_EN    = 0;
    localparam int B_RXON  = 1;
    localparam int B_TXON  = 2;
    localparam int B_TXCLR = 3;
    localparam int B_RXCLR = 4;
    localparam int B_DMAEN = 9;
    localparam int B_TXERR = 15;
    localparam int B_RXERR = 16;
    localparam int B_TXW   = 17;
    localparam int B_RXR   = 18;
    localparam int B_TXD   = 19;
    localparam int B_RXD   = 20;
    localparam int B_TXE   = 21;
    localparam int B_RXF   = 22;
    localparam int B_SYNC  = 24;
    localparam int B_WAKE  = 25;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DATA = 2'd1,
        A_THR  = 2'd2
    } addr_e;

    typedef struct packed {
        logic [7:0] tx_panic;
        logic [7:0] rx_panic;
        logic [7:0] tx_req;
        logic [7:0] rx_req;
    } thr_t;

    typedef struct packed {
        logic en;
        logic rxon;
        logic txon;
        logic dmaen;
        logic sync_req;
        logic wake_req;
    } ctrl_t;

    function automatic logic lvl_le(int unsigned lvl, logic [7:0] lim);
        return lvl <= 32'(lim);
    endfunction

    function automatic logic lvl_ge(int unsigned lvl, logic [7:0] lim);
        return lvl >= 32'(lim);
    endfunction

endpackage

// File: rtl/afc_fifo.sv
module afc_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/afc_tick_timer.sv
module afc_tick_timer #(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    assign done = !start && tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(TICKS);
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
    import afc_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CLR_TICKS  = 2,
    parameter int SYNC_TICKS = 2,
    parameter int WAKE_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk_tick,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ser_tx_pop,
    output logic [31:0] ser_tx_data,
    input  logic        ser_rx_push,
    input  logic [31:0] ser_rx_data,
    output logic        tx_dreq,
    output logic        tx_panic,
    output logic        rx_dreq,
    output logic        rx_panic
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    ctrl_t ctrl_q;
    thr_t  thr_q;
    logic  tx_err_q, rx_err_q, awake_q, sync_rd_q;

    logic wr_ctrl, wr_data, wr_thr, rd_data;
    logic tx_ok, rx_ok, tx_underrun, rx_overrun;
    logic tx_flush, rx_flush, sync_done, wake_done;
    logic [31:0]      rx_head;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic dma_on, ctrl_en, ctrl_wake;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_data = reg_wr && (reg_addr == A_DATA);
    assign wr_thr  = reg_wr && (reg_addr == A_THR);
    assign rd_data = reg_rd && (reg_addr == A_DATA);

    assign tx_ok       = ctrl_q.en && ctrl_q.txon && awake_q;
    assign rx_ok       = ctrl_q.en && ctrl_q.rxon && awake_q;
    assign tx_underrun = ser_tx_pop && tx_ok && tx_empty;
    assign rx_overrun  = ser_rx_push && rx_ok && rx_full;
    assign ctrl_en     = ctrl_q.en;
    assign ctrl_wake   = ctrl_q.wake_req;

    afc_fifo #(.DEPTH(DEPTH), .DATA_W(32), .LVL_W(LVL_W)) tx_fifo_i (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_data), .wdata(reg_wdata),
        .pop(ser_tx_pop && tx_ok), .rdata(ser_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    afc_fifo #(.DEPTH(DEPTH), .DATA_W(32), .LVL_W(LVL_W)) rx_fifo_i (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(ser_rx_push && rx_ok), .wdata(ser_rx_data),
        .pop(rd_data), .rdata(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    afc_tick_timer #(.TICKS(CLR_TICKS)) tx_clr_i (
        .clk(clk), .rst(rst), .tick(sclk_tick),
        .start(wr_ctrl && reg_wdata[B_TXCLR]), .done(tx_flush)
    );

    afc_tick_timer #(.TICKS(CLR_TICKS)) rx_clr_i (
        .clk(clk), .rst(rst), .tick(sclk_tick),
        .start(wr_ctrl && reg_wdata[B_RXCLR]), .done(rx_flush)
    );

    afc_tick_timer #(.TICKS(SYNC_TICKS)) sync_i (
        .clk(clk), .rst(rst), .tick(sclk_tick),
        .start(wr_ctrl && (reg_wdata[B_SYNC] != ctrl_q.sync_req)),
        .done(sync_done)
    );

    afc_tick_timer #(.TICKS(WAKE_TICKS)) wake_i (
        .clk(clk), .rst(rst), .tick(sclk_tick),
        .start(wr_ctrl && reg_wdata[B_WAKE] && !ctrl_q.wake_req),
        .done(wake_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            thr_q     <= '0;
            tx_err_q  <= 1'b0;
            rx_err_q  <= 1'b0;
            awake_q   <= 1'b0;
            sync_rd_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en       <= reg_wdata[B_EN];
                ctrl_q.rxon     <= reg_wdata[B_RXON];
                ctrl_q.txon     <= reg_wdata[B_TXON];
                ctrl_q.dmaen    <= reg_wdata[B_DMAEN];
                ctrl_q.sync_req <= reg_wdata[B_SYNC];
                ctrl_q.wake_req <= reg_wdata[B_WAKE];
            end
            if (wr_thr) thr_q <= thr_t'(reg_wdata);
            tx_err_q <= (tx_err_q && !(wr_ctrl && reg_wdata[B_TXERR])) || tx_underrun;
            rx_err_q <= (rx_err_q && !(wr_ctrl && reg_wdata[B_RXERR])) || rx_overrun;
            if (wr_ctrl && !reg_wdata[B_WAKE]) awake_q <= 1'b0;
            else if (wake_done && ctrl_q.wake_req) awake_q <= 1'b1;
            if (sync_done) sync_rd_q <= ctrl_q.sync_req;
        end
    end

    assign dma_on   = ctrl_q.en && ctrl_q.dmaen;
    assign tx_dreq  = dma_on && lvl_le(32'(tx_level), thr_q.tx_req);
    assign tx_panic = dma_on && lvl_le(32'(tx_level), thr_q.tx_panic);
    assign rx_dreq  = dma_on && lvl_ge(32'(rx_level), thr_q.rx_req);
    assign rx_panic = dma_on && lvl_ge(32'(rx_level), thr_q.rx_panic);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]    = ctrl_q.en;
                reg_rdata[B_RXON]  = ctrl_q.rxon;
                reg_rdata[B_TXON]  = ctrl_q.txon;
                reg_rdata[B_DMAEN] = ctrl_q.dmaen;
                reg_rdata[B_TXERR] = tx_err_q;
                reg_rdata[B_RXERR] = rx_err_q;
                reg_rdata[B_TXW]   = lvl_le(32'(tx_level), thr_q.tx_req);
                reg_rdata[B_RXR]   = lvl_ge(32'(rx_level), thr_q.rx_req);
                reg_rdata[B_TXD]   = !tx_full;
                reg_rdata[B_RXD]   = !rx_empty;
                reg_rdata[B_TXE]   = tx_empty;
                reg_rdata[B_RXF]   = rx_full;
                reg_rdata[B_SYNC]  = sync_rd_q;
                reg_rdata[B_WAKE]  = ctrl_q.wake_req;
            end
            A_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
            A_THR:   reg_rdata = thr_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/audio_fifo_ctrl_chk.sv
module audio_fifo_ctrl_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_dreq,
    input logic             tx_panic,
    input logic             rx_dreq,
    input logic             rx_panic,
    input logic             en,
    input logic             dmaen,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             sync_done,
    input logic             sync_rd,
    input logic             awake,
    input logic             wake_req
);
    p_dma_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_dreq || tx_panic || rx_dreq || rx_panic) |-> (en && dmaen));

    p_tx_flush_r9: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_level == '0));

    p_rx_flush_r9: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_level == '0));

    p_sync_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sync_done |=> $stable(sync_rd));

    p_wake_req_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(awake) |-> wake_req);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));
endmodule

bind audio_fifo_ctrl audio_fifo_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst(rst),
    .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
    .en(ctrl_en), .dmaen(dma_on), .tx_level(tx_level), .rx_level(rx_level),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .sync_done(sync_done),
    .sync_rd(sync_rd_q), .awake(awake_q), .wake_req(ctrl_wake)
);

// File: tb/audio_fifo_ctrl_tb_top.sv
module audio_fifo_ctrl_tb_top;
    localparam int DEPTH = 8;
    localparam logic [31:0] CB = 32'h0200_0207;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_tick = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
    logic [31:0] ser_tx_data, ser_rx_data = '0;
    logic        tx_dreq, tx_panic, rx_dreq, rx_panic;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] exp_tx[$], exp_rx[$];

    always #10 clk = ~clk;

    audio_fifo_ctrl #(.DEPTH(DEPTH), .CLR_TICKS(2), .SYNC_TICKS(2), .WAKE_TICKS(4)) dut_i (
        .clk(clk), .rst(rst), .sclk_tick(sclk_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ctrl_bit(int b, string req, logic exp);
        reg_addr = 2'd0;
        #1;
        check(req, 32'(reg_rdata[b]), 32'(exp));
    endtask

    task automatic tick();
        @(negedge clk); sclk_tick = 1'b1;
        @(negedge clk); sclk_tick = 1'b0;
    endtask

    task automatic ser_push(logic [31:0] d);
        @(negedge clk); ser_rx_data = d; ser_rx_push = 1'b1;
        @(negedge clk); ser_rx_push = 1'b0;
    endtask

    task automatic ser_pop(string req, bit compare);
        @(negedge clk); ser_tx_pop = 1'b1;
        #1;
        if (compare) check(req, ser_tx_data, exp_tx.pop_front());
        @(negedge clk); ser_tx_pop = 1'b0;
    endtask

    task automatic cpu_pop(string req);
        @(negedge clk); reg_addr = 2'd1; reg_rd = 1'b1;
        #1;
        check(req, reg_rdata, exp_rx.pop_front());
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic dma_check(string req, logic [3:0] exp);
        #1;
        check(req, {28'd0, tx_dreq, tx_panic, rx_dreq, rx_panic}, {28'd0, exp});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        reg_addr = 2'd0; #1;
        check("R1 ctrl", reg_rdata, 32'h002E_0000);
        reg_addr = 2'd2; #1;
        check("R1 thr", reg_rdata, 32'h0);
        dma_check("R1 dma", 4'b0000);

        // R4 threshold layout: rx_req=2 tx_req=3 rx_panic=6 tx_panic=1
        reg_write(2'd2, 32'h0106_0302);
        reg_addr = 2'd2; #1;
        check("R4 thr readback", reg_rdata, 32'h0106_0302);

        // R11 wake delay
        reg_write(2'd0, CB);
        ser_push(32'hA1);
        ctrl_bit(20, "R11 before wake", 1'b0);
        repeat (3) tick();
        ser_push(32'hA2);
        ctrl_bit(20, "R11 three ticks", 1'b0);
        tick();
        ser_push(32'hB0); exp_rx.push_back(32'hB0);
        ctrl_bit(20, "R11 awake", 1'b1);

        // R5 receive thresholds
        dma_check("R5 rx level1", 4'b1100);
        ser_push(32'hB1); exp_rx.push_back(32'hB1);
        dma_check("R5 rx level2", 4'b1110);
        for (int i = 2; i < 6; i++) begin
            ser_push(32'hB0 + 32'(i)); exp_rx.push_back(32'hB0 + 32'(i));
        end
        dma_check("R5 rx level6", 4'b1111);
        ser_push(32'hB6); exp_rx.push_back(32'hB6);
        ser_push(32'hB7); exp_rx.push_back(32'hB7);
        ctrl_bit(22, "R3 rx full", 1'b1);
        ser_push(32'hDEAD);
        ctrl_bit(16, "R8 overrun flag", 1'b1);
        for (int i = 0; i < 8; i++) cpu_pop("R3 R8 rx order");
        ctrl_bit(20, "R3 rx drained", 1'b0);
        reg_write(2'd0, CB | 32'h0001_0000);
        ctrl_bit(16, "R8 w1c", 1'b0);

        // R2/R4 transmit
        dma_check("R4 tx empty", 4'b1100);
        for (int i = 0; i < 5; i++) begin
            reg_write(2'd1, 32'hC0 + 32'(i)); exp_tx.push_back(32'hC0 + 32'(i));
        end
        dma_check("R4 tx level5", 4'b0000);
        ser_pop("R2 order", 1); ser_pop("R2 order", 1);
        dma_check("R4 tx level3", 4'b1000);
        ser_pop("R2 order", 1); ser_pop("R2 order", 1);
        dma_check("R4 tx level1", 4'b1100);
        ser_pop("R2 order", 1);
        ctrl_bit(21, "R2 tx empty", 1'b1);
        ctrl_bit(15, "R7 no err yet", 1'b0);
        ser_pop("R7", 0);
        ctrl_bit(15, "R7 underrun flag", 1'b1);
        reg_write(2'd0, CB | 32'h0000_8000);
        ctrl_bit(15, "R7 w1c", 1'b0);

        for (int i = 0; i < 9; i++) begin
            reg_write(2'd1, 32'hD0 + 32'(i));
            if (i < 8) exp_tx.push_back(32'hD0 + 32'(i));
        end
        ctrl_bit(19, "R2 tx full", 1'b0);
        ser_pop("R2 full order", 1);

        // R9 clear timing
        reg_write(2'd0, CB | 32'h0000_0008);
        tick();
        ctrl_bit(21, "R9 one tick", 1'b0);
        tick();
        ctrl_bit(21, "R9 two ticks", 1'b1);
        exp_tx.delete();

        // R6 DMA gating
        reg_write(2'd0, CB & ~32'h0000_0200);
        dma_check("R6 dma off", 4'b0000);
        reg_write(2'd0, CB);
        dma_check("R6 dma on", 4'b1100);

        // R10 sync
        reg_write(2'd0, CB | 32'h0100_0000);
        ctrl_bit(24, "R10 immediate", 1'b0);
        tick();
        ctrl_bit(24, "R10 one tick", 1'b0);
        tick();
        ctrl_bit(24, "R10 two ticks", 1'b1);

        finished = 1;
        finish_run();
    end
endmodule